// File: doc/BRIEF.md
# DMA Channel Pending and Busy Tracker

This block keeps the scheduling state of every channel in a multi-channel DMA controller. It has eight channels by default. Each channel has a trigger, an enable level, and suspend and resume pulses. The block tracks three things per channel:

- whether the channel is waiting for the arbiter (its request line),
- whether it has an outstanding transfer (its pending flag),
- whether a transfer request is in progress across granted beats (its busy flag).

An external arbiter reads the request vector and answers with a grant naming one channel. After the granted beats, the datapath reports a completion for that channel. The completion carries one of four follow-up actions.

The pending flag and the request line are kept apart on purpose. A suspended channel keeps its pending flag but drops out of the request vector. When it is resumed, it competes again. A disabled channel loses both. The busy flag survives requeued beats and clears when the transfer request ends.

Top module: `dma_chan_tracker`

## Requirements
- R1: A trigger on a channel that is enabled and not suspended sets that channel's `pend_o` and `req_o` bits at the next rising edge.
- R2: A grant naming a channel whose `req_o` bit is set clears that channel's `pend_o` and sets its `busy_o` at the next edge. A grant naming a channel whose `req_o` bit is clear changes nothing.
- R3: A completion for a busy channel with `done_act_i` = 0 (requeue) sets `pend_o` and `req_o` again and leaves `busy_o` set.
- R4: A completion for a busy channel with `done_act_i` = 1 (wait for trigger) clears `busy_o`. The channel stays out of the request vector.
- R5: A suspend pulse on a pending channel clears its `req_o` bit from the next edge onward and keeps its `pend_o` bit set.
- R6: A resume pulse on a suspended channel that is still pending sets its `req_o` bit again at the next edge.
- R7: Driving a channel's `enable_i` bit low clears its `req_o` bit at once. It clears its `pend_o` and `busy_o` bits at the next edge.
- R8: A trigger on a channel that is disabled or suspended is dropped. After the channel is enabled or resumed, it stays out of the request vector until a new trigger arrives.
- R9: A completion with `done_act_i` = 2 (suspend) clears `busy_o` and suspends the channel. Triggers are then dropped until a resume arrives.
- R10: While `rst_n` is low at a rising edge, all pending, busy and suspend state is cleared, so every output reads zero.
- R11: A completion with `done_act_i` = 3 (disable) clears `busy_o` of that channel.
- R12: Channels are independent. Triggers on several channels in the same cycle all set their own bits, and a grant or completion affects only the channel it names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | N | Per-channel transfer trigger pulse |
| enable_i | input | N | Per-channel enable level |
| susp_i | input | N | Per-channel suspend pulse (wins over resume in the same cycle) |
| resume_i | input | N | Per-channel resume pulse |
| grant_vld_i | input | 1 | Arbiter grant valid |
| grant_id_i | input | $clog2(N) | Granted channel number |
| done_vld_i | input | 1 | Completion valid |
| done_id_i | input | $clog2(N) | Channel that finished its granted beats |
| done_act_i | input | 2 | Follow-up: 0 requeue, 1 wait, 2 suspend, 3 disable |
| req_o | output | N | Request vector to the arbiter (queue membership) |
| pend_o | output | N | Pending flags |
| busy_o | output | N | Busy flags |

## Verification
`pend_o` and `busy_o` are registered, so they are due one rising edge after the stimulus cycle. `req_o` follows the registered flags plus the live enable level. It therefore also moves one edge after a trigger, grant, suspend or resume, but it falls in the same cycle that an enable bit goes low. Each step of the bench holds its inputs from a falling edge through the following rising edge. It then samples all three outputs 5 ns after that rising edge, before any input changes, so every expected value reflects exactly one edge of state update and the current enable level.

// File: rtl/dma_tracker_pkg.sv
// Shared types for the DMA channel tracker.
// Assumes: the completion action is a 2-bit code whose values are fixed by
// the datapath that reports them.
package dma_tracker_pkg;

    // Follow-up action reported after a channel's granted beats
    typedef enum logic [1:0] {
        ACT_REQUEUE = 2'd0,
        ACT_WAIT    = 2'd1,
        ACT_SUSPEND = 2'd2,
        ACT_DISABLE = 2'd3
    } done_act_e;

    // Per-channel decoded events for one cycle
    typedef struct packed {
        logic grant;
        logic done_requeue;
        logic done_wait;
        logic done_susp;
        logic done_dis;
    } chan_evt_t;

endpackage

// File: rtl/dma_evt_decode.sv
// Turns the arbiter grant and the completion report into one event record
// per channel.
// Assumes: at most one grant and one completion per cycle; ids are in range.
module dma_evt_decode
    import dma_tracker_pkg::*;
#(
    parameter int N   = 8,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            grant_vld_i,
    input  logic [IDW-1:0]  grant_id_i,
    input  logic            done_vld_i,
    input  logic [IDW-1:0]  done_id_i,
    input  logic [1:0]      done_act_i,
    output chan_evt_t       evt_o [N]
);

    done_act_e act;
    assign act = done_act_e'(done_act_i);

    for (genvar k = 0; k < N; k++) begin : g_dec
        logic grant_hit;
        logic done_hit;

        assign grant_hit = grant_vld_i && (grant_id_i == IDW'(k));
        assign done_hit  = done_vld_i  && (done_id_i  == IDW'(k));

        // Decode the completion action for this channel
        always_comb begin
            evt_o[k]              = '0;
            evt_o[k].grant        = grant_hit;
            evt_o[k].done_requeue = done_hit && (act == ACT_REQUEUE);
            evt_o[k].done_wait    = done_hit && (act == ACT_WAIT);
            evt_o[k].done_susp    = done_hit && (act == ACT_SUSPEND);
            evt_o[k].done_dis     = done_hit && (act == ACT_DISABLE);
        end
    end

endmodule

// File: rtl/dma_chan_slice.sv
// State of one DMA channel: pending flag, busy flag and suspend flag.
// Queue membership (the request line) is derived as pending, not suspended
// and enabled.
// Assumes: a completion is only meaningful for a busy channel, and a grant
// only for a requesting channel. Anything else is ignored.
module dma_chan_slice
    import dma_tracker_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      trig_i,
    input  logic      susp_i,
    input  logic      resume_i,
    input  chan_evt_t evt_i,
    output logic      req_o,
    output logic      pend_o,
    output logic      busy_o,
    output logic      susp_o
);

    logic pend_q, busy_q, susp_q;
    logic pend_n, busy_n, susp_n;

    assign req_o  = pend_q && !susp_q && en_i;
    assign pend_o = pend_q;
    assign busy_o = busy_q;
    assign susp_o = susp_q;

    // Next-state rules: suspend, then grant, completion and trigger, then disable
    always_comb begin
        susp_n = susp_q;
        if (susp_i || (busy_q && evt_i.done_susp)) begin
            susp_n = 1'b1;
        end else if (resume_i) begin
            susp_n = 1'b0;
        end

        pend_n = pend_q;
        busy_n = busy_q;

        if (evt_i.grant && req_o) begin
            pend_n = 1'b0;
            busy_n = 1'b1;
        end

        if (busy_q) begin
            if (evt_i.done_requeue) begin
                pend_n = 1'b1;
            end
            if (evt_i.done_wait || evt_i.done_susp || evt_i.done_dis) begin
                busy_n = 1'b0;
            end
        end

        if (trig_i && !susp_n) begin
            pend_n = 1'b1;
        end

        if (!en_i) begin
            pend_n = 1'b0;
            busy_n = 1'b0;
            susp_n = 1'b0;
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            pend_q <= pend_n;
            busy_q <= busy_n;
            susp_q <= susp_n;
        end
    end

endmodule

// File: rtl/dma_chan_tracker.sv
// Top of the per-channel scheduling tracker. Decodes grant and completion
// events, then keeps one state slice per channel.
// Assumes: the arbiter only samples req_o; policy lives outside this block.
module dma_chan_tracker
    import dma_tracker_pkg::*;
#(
    parameter int N   = 8,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    trig_i,
    input  logic [N-1:0]    enable_i,
    input  logic [N-1:0]    susp_i,
    input  logic [N-1:0]    resume_i,
    input  logic            grant_vld_i,
    input  logic [IDW-1:0]  grant_id_i,
    input  logic            done_vld_i,
    input  logic [IDW-1:0]  done_id_i,
    input  logic [1:0]      done_act_i,
    output logic [N-1:0]    req_o,
    output logic [N-1:0]    pend_o,
    output logic [N-1:0]    busy_o
);

    chan_evt_t    evt [N];
    logic [N-1:0] susp_q;

    dma_evt_decode #(.N(N)) u_dec (
        .grant_vld_i (grant_vld_i),
        .grant_id_i  (grant_id_i),
        .done_vld_i  (done_vld_i),
        .done_id_i   (done_id_i),
        .done_act_i  (done_act_i),
        .evt_o       (evt)
    );

    for (genvar k = 0; k < N; k++) begin : g_ch
        dma_chan_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (enable_i[k]),
            .trig_i   (trig_i[k]),
            .susp_i   (susp_i[k]),
            .resume_i (resume_i[k]),
            .evt_i    (evt[k]),
            .req_o    (req_o[k]),
            .pend_o   (pend_o[k]),
            .busy_o   (busy_o[k]),
            .susp_o   (susp_q[k])
        );
    end

endmodule

// File: rtl/dma_chan_tracker_chk.sv
// Property checker for dma_chan_tracker, bound to every instance.
// Assumes: it observes the top's ports plus its per-channel suspend flags.
module dma_chan_tracker_chk #(
    parameter int N   = 8,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    trig_i,
    input logic [N-1:0]    enable_i,
    input logic [N-1:0]    susp_i,
    input logic            grant_vld_i,
    input logic [IDW-1:0]  grant_id_i,
    input logic            done_vld_i,
    input logic [IDW-1:0]  done_id_i,
    input logic [1:0]      done_act_i,
    input logic [N-1:0]    req_o,
    input logic [N-1:0]    pend_o,
    input logic [N-1:0]    busy_o,
    input logic [N-1:0]    susp_q
);

    for (genvar k = 0; k < N; k++) begin : g_chk
        logic gnt_k, done_k;
        assign gnt_k  = grant_vld_i && (grant_id_i == IDW'(k));
        assign done_k = done_vld_i  && (done_id_i  == IDW'(k));

        AST_TRIG_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_i[k] && enable_i[k] && !susp_q[k] && !susp_i[k]
             && !(done_k && busy_o[k] && done_act_i == 2'd2)) |=> pend_o[k]); // R1

        AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_k && req_o[k] && !trig_i[k] && !done_k) |=> (!pend_o[k] && busy_o[k])); // R2

        AST_REQUEUE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            (done_k && busy_o[k] && done_act_i == 2'd0 && enable_i[k]) |=> (pend_o[k] && busy_o[k])); // R3

        AST_WAIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (done_k && busy_o[k] && done_act_i == 2'd1 && !gnt_k) |=> !busy_o[k]); // R4

        AST_SUSP_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (susp_i[k] && enable_i[k] && pend_o[k] && !gnt_k) |=> (pend_o[k] && !req_o[k])); // R5

        AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !enable_i[k] |=> (!pend_o[k] && !busy_o[k])); // R7
    end

endmodule

bind dma_chan_tracker dma_chan_tracker_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .enable_i    (enable_i),
    .susp_i      (susp_i),
    .grant_vld_i (grant_vld_i),
    .grant_id_i  (grant_id_i),
    .done_vld_i  (done_vld_i),
    .done_id_i   (done_id_i),
    .done_act_i  (done_act_i),
    .req_o       (req_o),
    .pend_o      (pend_o),
    .busy_o      (busy_o),
    .susp_q      (susp_q)
);

// File: tb/sim_dma_chan_tracker.sv
// Bench for dma_chan_tracker: a vector table walked step by step, then
// directed reset checks.
module sim_dma_chan_tracker;

    localparam int N = 8;
    localparam int STEPS = 27;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] trig_i, enable_i, susp_i, resume_i;
    logic       grant_vld_i, done_vld_i;
    logic [2:0] grant_id_i, done_id_i;
    logic [1:0] done_act_i;
    logic [7:0] req_o, pend_o, busy_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_chan_tracker #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .enable_i(enable_i),
        .susp_i(susp_i), .resume_i(resume_i), .grant_vld_i(grant_vld_i),
        .grant_id_i(grant_id_i), .done_vld_i(done_vld_i), .done_id_i(done_id_i),
        .done_act_i(done_act_i), .req_o(req_o), .pend_o(pend_o), .busy_o(busy_o)
    );

    // Fields: trig, en, susp, resume, gv, gid, dv, did, act, exp req, exp pend, exp busy
    localparam logic [65:0] TBL [STEPS] = '{
        {8'h00,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // idle
        {8'h05,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h05,8'h05,8'h00}, // R1 R12
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd0,1'b0,3'd0,2'd0,8'h04,8'h04,8'h01}, // R2
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd5,1'b0,3'd0,2'd0,8'h04,8'h04,8'h01}, // R2 ignored grant
        {8'h00,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b1,3'd0,2'd0,8'h05,8'h05,8'h01}, // R3
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd0,1'b0,3'd0,2'd0,8'h04,8'h04,8'h01}, // R2
        {8'h00,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b1,3'd0,2'd1,8'h04,8'h04,8'h00}, // R4
        {8'h00,8'hFF,8'h04,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h04,8'h00}, // R5
        {8'h00,8'hFF,8'h08,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h04,8'h00}, // R8 setup
        {8'h08,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h04,8'h00}, // R8 suspended
        {8'h00,8'hFF,8'h00,8'h0C,1'b0,3'd0,1'b0,3'd0,2'd0,8'h04,8'h04,8'h00}, // R6 R8
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd2,1'b0,3'd0,2'd0,8'h00,8'h00,8'h04}, // R2
        {8'h00,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b1,3'd2,2'd2,8'h00,8'h00,8'h00}, // R9
        {8'h04,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // R9 dropped
        {8'h00,8'hFF,8'h00,8'h04,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // R9 resume
        {8'h02,8'hFD,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // R8 disabled
        {8'h00,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // R8 not kept
        {8'h02,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h02,8'h02,8'h00}, // R1
        {8'h00,8'hFD,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // R7
        {8'h02,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h02,8'h02,8'h00}, // R1
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd1,1'b0,3'd0,2'd0,8'h00,8'h00,8'h02}, // R2
        {8'h00,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b1,3'd1,2'd3,8'h00,8'h00,8'h00}, // R11
        {8'h02,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h02,8'h02,8'h00}, // R1
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd1,1'b0,3'd0,2'd0,8'h00,8'h00,8'h02}, // R2
        {8'h00,8'hFD,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'h00,8'h00,8'h00}, // R7 busy
        {8'hF0,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0,3'd0,2'd0,8'hF0,8'hF0,8'h00}, // R12
        {8'h00,8'hFF,8'h00,8'h00,1'b1,3'd7,1'b0,3'd0,2'd0,8'h70,8'h70,8'h80}  // R12 R2
    };

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trig_i = '0; enable_i = 8'hFF; susp_i = '0; resume_i = '0;
        grant_vld_i = 1'b0; grant_id_i = '0;
        done_vld_i = 1'b0; done_id_i = '0; done_act_i = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        chk("R10", "req after reset",  req_o,  8'h00);
        chk("R10", "pend after reset", pend_o, 8'h00);
        chk("R10", "busy after reset", busy_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < STEPS; i++) begin
            trig_i      = TBL[i][65:58];
            enable_i    = TBL[i][57:50];
            susp_i      = TBL[i][49:42];
            resume_i    = TBL[i][41:34];
            grant_vld_i = TBL[i][33];
            grant_id_i  = TBL[i][32:30];
            done_vld_i  = TBL[i][29];
            done_id_i   = TBL[i][28:26];
            done_act_i  = TBL[i][25:24];
            @(posedge clk);
            #5;
            chk($sformatf("step%0d", i), "req",  req_o,  TBL[i][23:16]);
            chk($sformatf("step%0d", i), "pend", pend_o, TBL[i][15:8]);
            chk($sformatf("step%0d", i), "busy", busy_o, TBL[i][7:0]);
            @(negedge clk);
        end

        // R10: reset with live pending and busy state clears everything
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        chk("R10", "req mid-run reset",  req_o,  8'h00);
        chk("R10", "pend mid-run reset", pend_o, 8'h00);
        chk("R10", "busy mid-run reset", busy_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: a trigger right after reset release works again
        trig_i = 8'h81;
        @(posedge clk);
        #5;
        chk("R1", "pend after reset release", pend_o, 8'h81);
        chk("R1", "req after reset release",  req_o,  8'h81);
        @(negedge clk);
        idle_inputs();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule